// File: doc/BRIEF.md
# Paging MMU Control Register File

This block is the software-facing control and status front end of a two-level paging MMU. A host writes and reads ten 32-bit word registers over a simple single-cycle bus. It writes encoded values to one command register to turn translation on or off, ask for or release a stall, flush the translation cache, acknowledge a page fault, or return everything to power-on values. The block holds the paging, stall and fault state and drives them to a separate translation engine. It also sends that engine one-cycle invalidate pulses.

The engine reports page faults (with the faulting virtual address and whether the access was a write), read bus errors, an idle indication and the state of its replay buffer. Fault and bus-error events set raw interrupt bits. Software can mask these bits and clear them by writing ones, and the masked bits drive one interrupt line.

Reads are combinational from registered state. A write takes effect at the clock edge where `reg_we` is sampled, so its effect is visible on the following cycle.

Top module: `mmu_ctl_regs`

## Requirements
- R1: The directory base register (byte offset 0x00) stores only bits 31:12 of a write and reads zero in bits 11:0, so writing 0xCAFEBABE reads back 0xCAFEB000; the same value drives `dir_base`.
- R2: Command code 0, written to the command register (offset 0x08), sets paging on, and code 1 clears it. The change shows on `paging_en` and in status bit 0 (status at offset 0x04) one cycle after the write.
- R3: Command codes 2 (request stall) and 3 (release stall) change `stall_req` only when paging is on and no page fault is active. Otherwise they leave it unchanged.
- R4: Status reports bit 2 as stall requested AND `eng_idle`, bit 31 as the inverse of bit 2, bit 3 as `eng_idle` and bit 4 as `eng_replay_empty`.
- R5: An `eng_fault` pulse with no fault active sets status bit 1. It also records `eng_fault_addr` in the fault address register (offset 0x0C) and `eng_fault_write` in status bit 5. A further fault while one is active leaves the address unchanged. Every fault pulse sets raw interrupt bit 0 (raw at offset 0x14).
- R6: Command code 5 clears the active page fault (status bit 1).
- R7: An `eng_bus_err` pulse sets raw interrupt bit 1. Writing 1s to the clear register (offset 0x18) clears the matching raw bits. A new event in the same cycle as its clear leaves the bit set.
- R8: The masked status (offset 0x20) equals raw AND the mask register (offset 0x1C, bits 1:0), and `irq` is high exactly when the masked status is nonzero.
- R9: Command code 4 produces `zap_all` high for exactly one cycle, one cycle after the write.
- R10: A write to the line-invalidate register (offset 0x10) produces `zap_line` high for one cycle, one cycle after the write, with `zap_line_addr` equal to the written value.
- R11: Command code 6 returns paging, stall, fault, directory base, mask, raw interrupts and gating to their power-on value of zero.
- R12: A command write whose value is 7 or larger changes no state.
- R13: The gating register (offset 0x24) stores and reads back the low GATE_W bits of a write (default 4) and drives `gate_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| eng_idle | input | 1 | Engine has no access in flight |
| eng_replay_empty | input | 1 | Engine replay buffer is empty |
| eng_fault | input | 1 | Page fault event pulse |
| eng_fault_write | input | 1 | Faulting access was a write |
| eng_fault_addr | input | 32 | Faulting virtual address |
| eng_bus_err | input | 1 | Read bus error event pulse |
| paging_en | output | 1 | Translation enabled |
| stall_req | output | 1 | Stall requested from the engine |
| dir_base | output | 32 | Page directory base address |
| zap_all | output | 1 | Flush-all pulse |
| zap_line | output | 1 | Single-line invalidate pulse |
| zap_line_addr | output | 32 | Address of the line to invalidate |
| gate_cfg | output | GATE_W | Gating configuration bits |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
The assertions check the following on every cycle:
- every flush pulse and line-invalidate pulse traces back to a matching write one cycle earlier;
- a rising stall request only ever follows a cycle where paging was on and no fault was active;
- command codes 0, 1, 5 and 6 have their effect on the next cycle;
- `irq` never rises with an all-zero mask.

Some behaviour can only be shown by the bench's scenarios:
- the directory base truncation;
- the fault address being held across a second fault;
- a clear that collides with a new event;
- stall status following the idle input;
- the full restore after a hard reset;
- agreement of the readback values with the bench model over a random mix of register writes and bus errors.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;

    localparam int unsigned DW = 32;

    // Byte offsets of the word registers
    localparam int unsigned OFS_DIR    = 'h00;
    localparam int unsigned OFS_STAT   = 'h04;
    localparam int unsigned OFS_CMD    = 'h08;
    localparam int unsigned OFS_FADDR  = 'h0C;
    localparam int unsigned OFS_ZLINE  = 'h10;
    localparam int unsigned OFS_RAW    = 'h14;
    localparam int unsigned OFS_CLR    = 'h18;
    localparam int unsigned OFS_MASK   = 'h1C;
    localparam int unsigned OFS_MSTAT  = 'h20;
    localparam int unsigned OFS_GATE   = 'h24;

    // Interrupt sources
    localparam int unsigned NUM_IRQ    = 2;
    localparam int unsigned IRQ_FAULT  = 0;
    localparam int unsigned IRQ_BUSERR = 1;

    // Status bit positions
    localparam int unsigned ST_PAGING  = 0;
    localparam int unsigned ST_FAULT   = 1;
    localparam int unsigned ST_STALL   = 2;
    localparam int unsigned ST_IDLE    = 3;
    localparam int unsigned ST_REPLAY  = 4;
    localparam int unsigned ST_FWRITE  = 5;
    localparam int unsigned ST_NSTALL  = 31;

    localparam int unsigned CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_PAGE_ON    = 3'd0,
        CMD_PAGE_OFF   = 3'd1,
        CMD_STALL_ON   = 3'd2,
        CMD_STALL_OFF  = 3'd3,
        CMD_ZAP_ALL    = 3'd4,
        CMD_FAULT_DONE = 3'd5,
        CMD_HARD_RST   = 3'd6
    } mmu_cmd_e;

    typedef struct packed {
        logic dir;
        logic zline;
        logic clr;
        logic mask;
        logic gate;
    } wr_hit_t;

endpackage

// File: rtl/mmu_ctl_irq.sv
module mmu_ctl_irq #(
    parameter int unsigned NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hard_rst,
    input  logic           clr_we,
    input  logic           mask_we,
    input  logic [NUM-1:0] wbits,
    input  logic [NUM-1:0] events,
    output logic [NUM-1:0] raw,
    output logic [NUM-1:0] mask,
    output logic [NUM-1:0] masked,
    output logic           irq
);

    typedef struct packed {
        logic [NUM-1:0] raw;
        logic [NUM-1:0] mask;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we) begin
            st_d.raw = st_q.raw & ~wbits;
        end
        // a new event outranks a clear landing in the same cycle
        st_d.raw = st_d.raw | events;
        if (mask_we) begin
            st_d.mask = wbits;
        end
        if (hard_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw    = st_q.raw;
    assign mask   = st_q.mask;
    assign masked = st_q.raw & st_q.mask;
    assign irq    = |masked;

endmodule

// File: rtl/mmu_ctl_state.sv
module mmu_ctl_state
    import mmu_ctl_pkg::*;
#(
    parameter int unsigned BASE_LSB = 12,
    parameter int unsigned GATE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  mmu_cmd_e          cmd,
    input  wr_hit_t           hits,
    input  logic [DW-1:0]     wdata,
    input  logic              eng_fault,
    input  logic              eng_fault_write,
    input  logic [DW-1:0]     eng_fault_addr,
    output logic              paging,
    output logic              stall,
    output logic              fault,
    output logic              fault_wr,
    output logic [DW-1:0]     fault_addr,
    output logic [DW-1:0]     dir_base,
    output logic [GATE_W-1:0] gate,
    output logic              zap_all,
    output logic              zap_line,
    output logic [DW-1:0]     zap_addr
);

    localparam int unsigned DIR_W = DW - BASE_LSB;

    typedef struct packed {
        logic              paging;
        logic              stall;
        logic              fault;
        logic              fault_wr;
        logic [DW-1:0]     fault_addr;
        logic [DIR_W-1:0]  dir_hi;
        logic [GATE_W-1:0] gate;
        logic              zap_all;
        logic              zap_line;
        logic [DW-1:0]     zap_addr;
    } st_t;

    st_t st_d, st_q;
    logic stall_ok;

    assign stall_ok = st_q.paging && !st_q.fault;

    always_comb begin
        st_d          = st_q;
        st_d.zap_all  = 1'b0;
        st_d.zap_line = 1'b0;

        if (eng_fault && !st_q.fault) begin
            st_d.fault      = 1'b1;
            st_d.fault_wr   = eng_fault_write;
            st_d.fault_addr = eng_fault_addr;
        end

        if (cmd_vld) begin
            case (cmd)
                CMD_PAGE_ON:    st_d.paging = 1'b1;
                CMD_PAGE_OFF:   st_d.paging = 1'b0;
                CMD_STALL_ON:   if (stall_ok) st_d.stall = 1'b1;
                CMD_STALL_OFF:  if (stall_ok) st_d.stall = 1'b0;
                CMD_ZAP_ALL:    st_d.zap_all = 1'b1;
                CMD_FAULT_DONE: st_d.fault = 1'b0;
                default:        ;
            endcase
        end

        if (hits.dir) begin
            st_d.dir_hi = wdata[DW-1:BASE_LSB];
        end
        if (hits.zline) begin
            st_d.zap_line = 1'b1;
            st_d.zap_addr = wdata;
        end
        if (hits.gate) begin
            st_d.gate = wdata[GATE_W-1:0];
        end

        if (cmd_vld && cmd == CMD_HARD_RST) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign paging     = st_q.paging;
    assign stall      = st_q.stall;
    assign fault      = st_q.fault;
    assign fault_wr   = st_q.fault_wr;
    assign fault_addr = st_q.fault_addr;
    assign dir_base   = {st_q.dir_hi, {BASE_LSB{1'b0}}};
    assign gate       = st_q.gate;
    assign zap_all    = st_q.zap_all;
    assign zap_line   = st_q.zap_line;
    assign zap_addr   = st_q.zap_addr;

endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned BASE_LSB = 12,
    parameter int unsigned GATE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              eng_idle,
    input  logic              eng_replay_empty,
    input  logic              eng_fault,
    input  logic              eng_fault_write,
    input  logic [31:0]       eng_fault_addr,
    input  logic              eng_bus_err,
    output logic              paging_en,
    output logic              stall_req,
    output logic [31:0]       dir_base,
    output logic              zap_all,
    output logic              zap_line,
    output logic [31:0]       zap_line_addr,
    output logic [GATE_W-1:0] gate_cfg,
    output logic              irq
);

    wr_hit_t              hits;
    logic                 cmd_hit;
    logic                 cmd_vld;
    mmu_cmd_e             cmd;
    logic                 hard_rst;
    logic                 fault_act;
    logic                 fault_wr;
    logic [DW-1:0]        fault_addr;
    logic                 stall_act;
    logic [NUM_IRQ-1:0]   irq_raw;
    logic [NUM_IRQ-1:0]   irq_mask;
    logic [NUM_IRQ-1:0]   irq_masked;
    logic [NUM_IRQ-1:0]   irq_events;
    logic [DW-1:0]        status;

    always_comb begin
        cmd_hit    = reg_we && (reg_addr == ADDR_W'(OFS_CMD));
        hits.dir   = reg_we && (reg_addr == ADDR_W'(OFS_DIR));
        hits.zline = reg_we && (reg_addr == ADDR_W'(OFS_ZLINE));
        hits.clr   = reg_we && (reg_addr == ADDR_W'(OFS_CLR));
        hits.mask  = reg_we && (reg_addr == ADDR_W'(OFS_MASK));
        hits.gate  = reg_we && (reg_addr == ADDR_W'(OFS_GATE));
    end

    // codes beyond the defined set must not alias onto low codes
    assign cmd_vld  = cmd_hit && (reg_wdata[DW-1:CMD_W] == '0);
    assign cmd      = mmu_cmd_e'(reg_wdata[CMD_W-1:0]);
    assign hard_rst = cmd_vld && (cmd == CMD_HARD_RST);

    mmu_ctl_state #(
        .BASE_LSB (BASE_LSB),
        .GATE_W   (GATE_W)
    ) u_state (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_vld         (cmd_vld),
        .cmd             (cmd),
        .hits            (hits),
        .wdata           (reg_wdata),
        .eng_fault       (eng_fault),
        .eng_fault_write (eng_fault_write),
        .eng_fault_addr  (eng_fault_addr),
        .paging          (paging_en),
        .stall           (stall_req),
        .fault           (fault_act),
        .fault_wr        (fault_wr),
        .fault_addr      (fault_addr),
        .dir_base        (dir_base),
        .gate            (gate_cfg),
        .zap_all         (zap_all),
        .zap_line        (zap_line),
        .zap_addr        (zap_line_addr)
    );

    always_comb begin
        irq_events             = '0;
        irq_events[IRQ_FAULT]  = eng_fault;
        irq_events[IRQ_BUSERR] = eng_bus_err;
    end

    mmu_ctl_irq #(
        .NUM (NUM_IRQ)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hard_rst (hard_rst),
        .clr_we   (hits.clr),
        .mask_we  (hits.mask),
        .wbits    (reg_wdata[NUM_IRQ-1:0]),
        .events   (irq_events),
        .raw      (irq_raw),
        .mask     (irq_mask),
        .masked   (irq_masked),
        .irq      (irq)
    );

    assign stall_act = stall_req && eng_idle;

    always_comb begin
        status             = '0;
        status[ST_PAGING]  = paging_en;
        status[ST_FAULT]   = fault_act;
        status[ST_STALL]   = stall_act;
        status[ST_IDLE]    = eng_idle;
        status[ST_REPLAY]  = eng_replay_empty;
        status[ST_FWRITE]  = fault_wr;
        status[ST_NSTALL]  = !stall_act;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_DIR):   reg_rdata = dir_base;
            ADDR_W'(OFS_STAT):  reg_rdata = status;
            ADDR_W'(OFS_FADDR): reg_rdata = fault_addr;
            ADDR_W'(OFS_RAW):   reg_rdata = DW'(irq_raw);
            ADDR_W'(OFS_MASK):  reg_rdata = DW'(irq_mask);
            ADDR_W'(OFS_MSTAT): reg_rdata = DW'(irq_masked);
            ADDR_W'(OFS_GATE):  reg_rdata = DW'(gate_cfg);
            default:            reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mmu_ctl_chk.sv
module mmu_ctl_chk
    import mmu_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              paging_en,
    input logic              stall_req,
    input logic              fault_act,
    input logic              zap_all,
    input logic              zap_line,
    input logic [NUM-1:0]    irq_mask,
    input logic              irq
);

    logic cmd_wr;
    assign cmd_wr = reg_we && (reg_addr == ADDR_W'(OFS_CMD));

    // R9: a flush pulse needs a flush command one cycle before
    p_zap_all_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        zap_all |-> $past(cmd_wr && reg_wdata == 32'd4));

    // R10: a line pulse needs a write to the line register one cycle before
    p_zap_line_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        zap_line |-> $past(reg_we && reg_addr == ADDR_W'(OFS_ZLINE)));

    // R3: a stall request rises only from an allowed state
    p_stall_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_req) |-> $past(paging_en && !fault_act));

    // R2: paging commands take effect on the next cycle
    p_paging_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata == 32'd0) |=> paging_en);

    p_paging_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata == 32'd1) |=> !paging_en);

    // R6: fault acknowledge clears the fault
    p_fault_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata == 32'd5) |=> !fault_act);

    // R11: hard reset restores power-on control outputs
    p_hard_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata == 32'd6) |=> (!paging_en && !stall_req && !fault_act && !irq));

    // R8: no interrupt while every source is masked off
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_mask != '0));

endmodule

bind mmu_ctl_regs mmu_ctl_chk #(
    .ADDR_W (ADDR_W),
    .NUM    (mmu_ctl_pkg::NUM_IRQ)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .paging_en (paging_en),
    .stall_req (stall_req),
    .fault_act (fault_act),
    .zap_all   (zap_all),
    .zap_line  (zap_line),
    .irq_mask  (irq_mask),
    .irq       (irq)
);

// File: tb/tb_mmu_ctl_regs.sv
module tb_mmu_ctl_regs;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned GATE_W = 4;

    localparam logic [7:0] A_DIR = 8'h00, A_STAT = 8'h04, A_CMD = 8'h08,
                           A_FADDR = 8'h0C, A_ZLINE = 8'h10, A_RAW = 8'h14,
                           A_CLR = 8'h18, A_MASK = 8'h1C, A_MSTAT = 8'h20,
                           A_GATE = 8'h24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              eng_idle = 1'b1;
    logic              eng_replay_empty = 1'b1;
    logic              eng_fault = 1'b0;
    logic              eng_fault_write = 1'b0;
    logic [31:0]       eng_fault_addr = '0;
    logic              eng_bus_err = 1'b0;
    logic              paging_en;
    logic              stall_req;
    logic [31:0]       dir_base;
    logic              zap_all;
    logic              zap_line;
    logic [31:0]       zap_line_addr;
    logic [GATE_W-1:0] gate_cfg;
    logic              irq;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;

    always #5 clk = ~clk;

    mmu_ctl_regs #(.ADDR_W(ADDR_W), .GATE_W(GATE_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_idle(eng_idle),
        .eng_replay_empty(eng_replay_empty), .eng_fault(eng_fault),
        .eng_fault_write(eng_fault_write), .eng_fault_addr(eng_fault_addr),
        .eng_bus_err(eng_bus_err), .paging_en(paging_en), .stall_req(stall_req),
        .dir_base(dir_base), .zap_all(zap_all), .zap_line(zap_line),
        .zap_line_addr(zap_line_addr), .gate_cfg(gate_cfg), .irq(irq)
    );

    function automatic logic [31:0] exp_status(input logic pg, input logic flt,
                                               input logic st, input logic fw);
        logic sa;
        sa = st && eng_idle;
        return {!sa, 25'd0, fw, eng_replay_empty, eng_idle, sa, flt, pg};
    endfunction

    function automatic logic [31:0] exp_dir(input logic [31:0] w);
        return w & 32'hFFFF_F000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_fault(input logic [31:0] a, input logic w);
        @(negedge clk);
        eng_fault = 1'b1; eng_fault_addr = a; eng_fault_write = w;
        @(negedge clk);
        eng_fault = 1'b0;
    endtask

    task automatic pulse_buserr();
        @(negedge clk);
        eng_bus_err = 1'b1;
        @(negedge clk);
        eng_bus_err = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] m_dir, m_raw, m_mask, m_gate;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R11 values)
        rd(A_DIR, v);  chk("R11 reset dir", v, 32'h0);
        rd(A_STAT, v); chk("R4 reset status", v, 32'h8000_0018);
        chk("R2 reset paging", {31'd0, paging_en}, 32'd0);
        chk("R8 reset irq", {31'd0, irq}, 32'd0);

        // R1 directory base truncation
        wr(A_DIR, 32'hCAFE_BABE);
        rd(A_DIR, v); chk("R1 dir readback", v, 32'hCAFE_B000);
        chk("R1 dir port", dir_base, 32'hCAFE_B000);

        // R3 stall refused while paging off
        wr(A_CMD, 32'd2);
        chk("R3 stall refused paging off", {31'd0, stall_req}, 32'd0);

        // R2 paging on
        wr(A_CMD, 32'd0);
        chk("R2 paging on port", {31'd0, paging_en}, 32'd1);
        rd(A_STAT, v); chk("R2 paging on status", v, exp_status(1, 0, 0, 0));

        // R3/R4 stall with idle high then low
        wr(A_CMD, 32'd2);
        chk("R3 stall accepted", {31'd0, stall_req}, 32'd1);
        rd(A_STAT, v); chk("R4 stall active idle", v, exp_status(1, 0, 1, 0));
        eng_idle = 1'b0; eng_replay_empty = 1'b0;
        rd(A_STAT, v); chk("R4 stall busy", v, exp_status(1, 0, 1, 0));
        eng_idle = 1'b1; eng_replay_empty = 1'b1;
        wr(A_CMD, 32'd3);
        chk("R3 stall released", {31'd0, stall_req}, 32'd0);

        // R12 out-of-range commands
        wr(A_CMD, 32'd7);
        wr(A_CMD, 32'h0000_0101);
        rd(A_STAT, v); chk("R12 bad codes no effect", v, exp_status(1, 0, 0, 0));

        // R5 fault capture and hold
        pulse_fault(32'h1234_5678, 1'b1);
        rd(A_STAT, v);  chk("R5 fault status", v, exp_status(1, 1, 0, 1));
        rd(A_FADDR, v); chk("R5 fault addr", v, 32'h1234_5678);
        rd(A_RAW, v);   chk("R5 raw fault bit", v, 32'd1);
        chk("R8 masked off no irq", {31'd0, irq}, 32'd0);
        pulse_fault(32'hDEAD_0000, 1'b0);
        rd(A_FADDR, v); chk("R5 fault addr held", v, 32'h1234_5678);

        // R3 stall refused during fault
        wr(A_CMD, 32'd2);
        chk("R3 stall refused in fault", {31'd0, stall_req}, 32'd0);

        // R8 mask
        wr(A_MASK, 32'd3);
        rd(A_MSTAT, v); chk("R8 masked status", v, 32'd1);
        chk("R8 irq high", {31'd0, irq}, 32'd1);

        // R6 fault done
        wr(A_CMD, 32'd5);
        rd(A_STAT, v); chk("R6 fault cleared", v & 32'h2, 32'h0);
        rd(A_RAW, v);  chk("R6 raw kept", v, 32'd1);

        // R7 clear and bus error
        wr(A_CLR, 32'd1);
        rd(A_RAW, v); chk("R7 clear fault bit", v, 32'd0);
        chk("R8 irq low", {31'd0, irq}, 32'd0);
        pulse_buserr();
        rd(A_RAW, v);   chk("R7 bus error bit", v, 32'd2);
        rd(A_MSTAT, v); chk("R8 masked bus error", v, 32'd2);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_CLR; reg_wdata = 32'd2; eng_bus_err = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; eng_bus_err = 1'b0;
        rd(A_RAW, v); chk("R7 event beats clear", v, 32'd2);
        wr(A_CLR, 32'd3);
        rd(A_RAW, v); chk("R7 cleared", v, 32'd0);

        // R9 flush pulse
        wr(A_CMD, 32'd4);
        chk("R9 zap_all high", {31'd0, zap_all}, 32'd1);
        @(negedge clk);
        chk("R9 zap_all one cycle", {31'd0, zap_all}, 32'd0);

        // R10 line pulse
        wr(A_ZLINE, 32'hABCD_1000);
        chk("R10 zap_line high", {31'd0, zap_line}, 32'd1);
        chk("R10 zap_line addr", zap_line_addr, 32'hABCD_1000);
        @(negedge clk);
        chk("R10 zap_line one cycle", {31'd0, zap_line}, 32'd0);

        // R13 gating
        wr(A_GATE, 32'hFFFF_FFF5);
        rd(A_GATE, v); chk("R13 gate readback", v, 32'd5);
        chk("R13 gate port", {28'd0, gate_cfg}, 32'd5);

        // R11 hard reset from a busy state
        wr(A_CMD, 32'd2);
        pulse_fault(32'h0000_4000, 1'b1);
        wr(A_CMD, 32'd6);
        rd(A_DIR, v);  chk("R11 dir cleared", v, 32'd0);
        rd(A_MASK, v); chk("R11 mask cleared", v, 32'd0);
        rd(A_RAW, v);  chk("R11 raw cleared", v, 32'd0);
        rd(A_GATE, v); chk("R11 gate cleared", v, 32'd0);
        rd(A_STAT, v); chk("R11 status restored", v, 32'h8000_0018);

        // R2 paging off
        wr(A_CMD, 32'd0);
        wr(A_CMD, 32'd1);
        chk("R2 paging off", {31'd0, paging_en}, 32'd0);

        // random mix against a model
        m_dir = '0; m_raw = '0; m_mask = '0; m_gate = '0;
        v = $urandom(32'd20240);
        for (int i = 0; i < 200; i++) begin
            logic [31:0] r;
            logic [31:0] d;
            r = $urandom() % 5;
            d = $urandom();
            case (r)
                0: begin wr(A_DIR, d);  m_dir = exp_dir(d); end
                1: begin wr(A_GATE, d); m_gate = {28'd0, d[3:0]}; end
                2: begin wr(A_MASK, d); m_mask = {30'd0, d[1:0]}; end
                3: begin wr(A_CLR, d);  m_raw = m_raw & ~{30'd0, d[1:0]}; end
                default: begin pulse_buserr(); m_raw = m_raw | 32'd2; end
            endcase
            rd(A_DIR, v);   chk("R1 random dir", v, m_dir);
            rd(A_GATE, v);  chk("R13 random gate", v, m_gate);
            rd(A_RAW, v);   chk("R7 random raw", v, m_raw);
            rd(A_MSTAT, v); chk("R8 random masked", v, m_raw & m_mask);
            chk("R8 random irq", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
        end

        finish_run();
    end

endmodule